// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation entries out of memory. A walk begins at a root entry whose location comes from a context table pointer and a context number. From there the block descends through up to three tables, fetching one 32-bit word per step over a simple request/response memory port. A final page entry can appear at any of the three table depths, so the block maps 16 MB, 256 KB and 4 KB pages.

Each fetched word is sorted by its two low bits into one of four kinds: empty, link to a further table, final page entry, or reserved. When the block reaches a page entry, it returns the physical address and the entry itself. If the entry's referenced flag is clear, or the access is a store and the entry's modified flag is clear, the block first stores the updated entry back to the word it came from. When translation is switched off, the address passes through unchanged and both loads and stores are allowed. Only one walk runs at a time. `busy` covers the walk, and a one-cycle `done` marks the cycle in which the results are valid.

Top module: `page_walker`

## Requirements
- R1: After reset, `busy`, `done` and `memReqValid` are all low.
- R2: With `cfgEnable` low when a walk starts, the block issues no memory access. At `done`, `paddr` equals the virtual address, `passAll` is 1, `fault` is 0 and `pageLevel` is 0.
- R3: The first read of a walk goes to (`cfgRootPtr` << 4) + (`cfgContext` << 4), modulo 2^32.
- R4: An entry whose bits 1:0 are 0 (empty) or 3 (reserved) ends the walk at any depth. The result is `fault` = 1, `pageLevel` = 0, `pte` equal to the raw entry, and no memory write.
- R5: A link entry (bits 1:0 = 1) leads to a next read at ((entry with bits 1:0 cleared) << 4) + 4 × index. The index is virtual address bits 31:24 after the root, bits 23:18 after the first table, and bits 17:12 after the second.
- R6: A page entry (bits 1:0 = 2) in the first table gives `pageLevel` = 1. The result is `paddr` = ((entry with bits 7:0 cleared) << 4) + virtual address bits 23:0.
- R7: A page entry in the second table gives `pageLevel` = 2 and adds virtual address bits 17:0 as the offset.
- R8: A page entry in the third table gives `pageLevel` = 3 and adds virtual address bits 11:0 as the offset.
- R9: A link entry in the third table, or a page entry returned by the root read, ends the walk with `fault` = 2, `pageLevel` = 0 and no memory write.
- R10: On a successful walk, `pte` is the entry with bit 5 (referenced) set. If bit 5 was clear in memory, the block writes that value back to the entry's own address. If the access is a load and bit 5 was already set, nothing is written.
- R11: On a store (`reqWrite` = 1), the returned and written-back entry also has bit 6 (modified) set. A write-back happens whenever bit 6 was clear, even when bit 5 was already set.
- R12: `reqValid` is ignored while `busy` is high. `done` lasts one cycle, and `busy` is low in the cycle after it.
- R13: While `memReqValid` is high and `memReqReady` is low, the request's address, direction and data stay unchanged and the request stays raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Start a walk (taken only when idle) |
| reqVaddr | input | 32 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a store access, 0 for a load |
| cfgEnable | input | 1 | Translation on; when low the address passes through |
| cfgRootPtr | input | 32 | Context table pointer (byte address >> 4) |
| cfgContext | input | CTX_W | Context number |
| memReqValid | output | 1 | Memory request raised |
| memReqReady | input | 1 | Memory accepts the request this cycle |
| memReqWrite | output | 1 | 1 for an entry write-back, 0 for a read |
| memReqAddr | output | 32 | Byte address of the entry |
| memReqWdata | output | 32 | Entry value for a write-back |
| memRspValid | input | 1 | Read data valid |
| memRspData | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse; results valid |
| paddr | output | 32 | Physical address |
| pte | output | 32 | Final (updated) entry, or the faulting entry |
| fault | output | 2 | 0 ok, 1 empty/reserved entry, 2 entry at wrong depth |
| pageLevel | output | 2 | Depth of the page entry (1, 2, 3), 0 otherwise |
| passAll | output | 1 | Translation bypassed; load and store both allowed |

## Verification
Several rules are checked on every cycle: the memory request holds steady under back-pressure, `done` is a single pulse followed by an idle cycle, every write-back carries a page-kind entry with the referenced flag set, and a completion reports a page depth exactly when it reports neither a fault nor a bypass. The arithmetic cannot be shown by those properties and is left to the bench scenarios: the root and per-depth read addresses, the three offset widths, and which walks write back and with what value. The same holds for fault classification at each depth and for a start request held across a busy walk being ignored.

// File: rtl/walk_pkg.sv
package walk_pkg;
  localparam int ADDR_W     = 32;
  localparam int NUM_LEVELS = 3;

  typedef enum logic [1:0] {
    ENT_EMPTY    = 2'd0,
    ENT_LINK     = 2'd1,
    ENT_PAGE     = 2'd2,
    ENT_RESERVED = 2'd3
  } entry_kind_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_XLATE = 2'd1,
    FLT_DEPTH = 2'd2
  } fault_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic       capture;
    logic       bypass;
    logic       descend;
    logic       takePage;
    logic       setFault;
    fault_e     faultCode;
    logic [1:0] level;     // depth of the entry just fetched (0 = root)
  } walk_strobe_t;

  // Lowest virtual address bit of the index consumed at a given depth;
  // depth 0 returns the address width (top of the first index).
  function automatic int levelLsb(input int lvl);
    case (lvl)
      0:       return ADDR_W;
      1:       return 24;
      2:       return 18;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/walk_dp.sv
module walk_dp
  import walk_pkg::*;
#(
  parameter int CTX_W          = 8,
  parameter int REF_BIT        = 5,
  parameter int MOD_BIT        = 6,
  parameter int ENTRY_SHIFT    = 4,
  parameter int ADDR_FIELD_LSB = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_strobe_t      strobe,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] cfgRootPtr,
  input  logic [CTX_W-1:0]  cfgContext,
  input  logic [ADDR_W-1:0] memRspData,
  output logic [1:0]        rspKind,
  output logic              rspNeedWb,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] entryOut,
  output logic [ADDR_W-1:0] paddrOut,
  output logic [1:0]        faultOut,
  output logic [1:0]        levelOut,
  output logic              passOut
);
  localparam int IDX_SCALE = 2;
  localparam logic [ADDR_W-1:0] REF_MASK = ADDR_W'(1) << REF_BIT;
  localparam logic [ADDR_W-1:0] MOD_MASK = ADDR_W'(1) << MOD_BIT;

  logic [ADDR_W-1:0] vaReg;
  logic              wrReg;

  // Per-depth index byte offsets and page offset masks
  logic [ADDR_W-1:0] idxOff  [1:NUM_LEVELS];
  logic [ADDR_W-1:0] offMask [1:NUM_LEVELS];

  for (genvar g = 1; g <= NUM_LEVELS; g++) begin : g_depth
    localparam int HI = levelLsb(g - 1);
    localparam int LO = levelLsb(g);
    assign idxOff[g]  = ADDR_W'(vaReg[HI-1:LO]) << IDX_SCALE;
    assign offMask[g] = (ADDR_W'(1) << LO) - ADDR_W'(1);
  end

  logic [ADDR_W-1:0] nextIdx, pageMask;
  always_comb begin
    case (strobe.level)
      2'd0:    nextIdx = idxOff[1];
      2'd1:    nextIdx = idxOff[2];
      default: nextIdx = idxOff[3];
    endcase
    case (strobe.level)
      2'd1:    pageMask = offMask[1];
      2'd2:    pageMask = offMask[2];
      default: pageMask = offMask[3];
    endcase
  end

  logic [ADDR_W-1:0] rootAddr, tableBase, pageBase, updEntry;
  assign rootAddr  = (cfgRootPtr << ENTRY_SHIFT) + (ADDR_W'(cfgContext) << ENTRY_SHIFT);
  assign tableBase = {memRspData[ADDR_W-1:2], 2'b00} << ENTRY_SHIFT;
  assign pageBase  = {memRspData[ADDR_W-1:ADDR_FIELD_LSB], {ADDR_FIELD_LSB{1'b0}}} << ENTRY_SHIFT;
  assign updEntry  = memRspData | REF_MASK | (wrReg ? MOD_MASK : '0);

  assign rspKind   = memRspData[1:0];
  assign rspNeedWb = !memRspData[REF_BIT] || (wrReg && !memRspData[MOD_BIT]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vaReg     <= '0;
      wrReg     <= 1'b0;
      fetchAddr <= '0;
      entryOut  <= '0;
      paddrOut  <= '0;
      faultOut  <= FLT_NONE;
      levelOut  <= 2'd0;
      passOut   <= 1'b0;
    end else begin
      if (strobe.capture) begin
        vaReg     <= reqVaddr;
        wrReg     <= reqWrite;
        fetchAddr <= rootAddr;
        entryOut  <= '0;
        paddrOut  <= strobe.bypass ? reqVaddr : '0;
        faultOut  <= FLT_NONE;
        levelOut  <= 2'd0;
        passOut   <= strobe.bypass;
      end
      if (strobe.descend) begin
        fetchAddr <= tableBase + nextIdx;
      end
      if (strobe.takePage) begin
        entryOut <= updEntry;
        paddrOut <= pageBase + (vaReg & pageMask);
        levelOut <= strobe.level;
      end
      if (strobe.setFault) begin
        entryOut <= memRspData;
        faultOut <= strobe.faultCode;
      end
    end
  end
endmodule

// File: rtl/walk_ctrl.sv
module walk_ctrl
  import walk_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reqValid,
  input  logic         cfgEnable,
  input  logic         memReqReady,
  input  logic         memRspValid,
  input  logic [1:0]   rspKind,
  input  logic         rspNeedWb,
  output walk_strobe_t strobe,
  output logic         memReqValid,
  output logic         memReqWrite,
  output logic         busy,
  output logic         done
);
  localparam logic [1:0] LAST_LEVEL = 2'(NUM_LEVELS);

  typedef enum logic [2:0] {
    S_IDLE, S_RD_REQ, S_RD_WAIT, S_WB_REQ, S_FIN
  } state_e;

  state_e     state, stateNext;
  logic [1:0] level, levelNext;

  always_comb begin
    stateNext        = state;
    levelNext        = level;
    strobe           = '0;
    strobe.faultCode = FLT_NONE;
    strobe.level     = level;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          strobe.capture = 1'b1;
          strobe.bypass  = !cfgEnable;
          levelNext      = 2'd0;
          stateNext      = cfgEnable ? S_RD_REQ : S_FIN;
        end
      end
      S_RD_REQ: begin
        if (memReqReady) stateNext = S_RD_WAIT;
      end
      S_RD_WAIT: begin
        if (memRspValid) begin
          case (entry_kind_e'(rspKind))
            ENT_LINK: begin
              if (level == LAST_LEVEL) begin
                strobe.setFault  = 1'b1;
                strobe.faultCode = FLT_DEPTH;
                stateNext        = S_FIN;
              end else begin
                strobe.descend = 1'b1;
                levelNext      = level + 2'd1;
                stateNext      = S_RD_REQ;
              end
            end
            ENT_PAGE: begin
              if (level == 2'd0) begin
                strobe.setFault  = 1'b1;
                strobe.faultCode = FLT_DEPTH;
                stateNext        = S_FIN;
              end else begin
                strobe.takePage = 1'b1;
                stateNext       = rspNeedWb ? S_WB_REQ : S_FIN;
              end
            end
            default: begin
              strobe.setFault  = 1'b1;
              strobe.faultCode = FLT_XLATE;
              stateNext        = S_FIN;
            end
          endcase
        end
      end
      S_WB_REQ: begin
        if (memReqReady) stateNext = S_FIN;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      level <= 2'd0;
    end else begin
      state <= stateNext;
      level <= levelNext;
    end
  end

  assign memReqValid = (state == S_RD_REQ) || (state == S_WB_REQ);
  assign memReqWrite = (state == S_WB_REQ);
  assign busy        = (state != S_IDLE);
  assign done        = (state == S_FIN);
endmodule

// File: rtl/page_walker.sv
module page_walker
  import walk_pkg::*;
#(
  parameter int CTX_W   = 8,
  parameter int REF_BIT = 5,
  parameter int MOD_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [31:0]       reqVaddr,
  input  logic              reqWrite,
  input  logic              cfgEnable,
  input  logic [31:0]       cfgRootPtr,
  input  logic [CTX_W-1:0]  cfgContext,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic              memReqWrite,
  output logic [31:0]       memReqAddr,
  output logic [31:0]       memReqWdata,
  input  logic              memRspValid,
  input  logic [31:0]       memRspData,
  output logic              busy,
  output logic              done,
  output logic [31:0]       paddr,
  output logic [31:0]       pte,
  output logic [1:0]        fault,
  output logic [1:0]        pageLevel,
  output logic              passAll
);
  walk_strobe_t strobe;
  logic [1:0]   rspKind;
  logic         rspNeedWb;

  walk_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .reqValid    (reqValid),
    .cfgEnable   (cfgEnable),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .rspKind     (rspKind),
    .rspNeedWb   (rspNeedWb),
    .strobe      (strobe),
    .memReqValid (memReqValid),
    .memReqWrite (memReqWrite),
    .busy        (busy),
    .done        (done)
  );

  walk_dp #(
    .CTX_W   (CTX_W),
    .REF_BIT (REF_BIT),
    .MOD_BIT (MOD_BIT)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .reqVaddr   (reqVaddr),
    .reqWrite   (reqWrite),
    .cfgRootPtr (cfgRootPtr),
    .cfgContext (cfgContext),
    .memRspData (memRspData),
    .rspKind    (rspKind),
    .rspNeedWb  (rspNeedWb),
    .fetchAddr  (memReqAddr),
    .entryOut   (pte),
    .paddrOut   (paddr),
    .faultOut   (fault),
    .levelOut   (pageLevel),
    .passOut    (passAll)
  );

  assign memReqWdata = pte;
endmodule

// File: rtl/page_walker_chk.sv
module page_walker_chk #(
  parameter int REF_BIT = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        memReqValid,
  input logic        memReqReady,
  input logic        memReqWrite,
  input logic [31:0] memReqAddr,
  input logic [31:0] memReqWdata,
  input logic [1:0]  fault,
  input logic [1:0]  pageLevel,
  input logic        passAll
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !memReqValid);

  p_req_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memReqAddr) && $stable(memReqWrite) && $stable(memReqWdata)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  p_bypass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && passAll) |-> (fault == 2'd0 && pageLevel == 2'd0));

  p_fault_nodepth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 2'd0) |-> (pageLevel == 2'd0 && !passAll));

  p_ok_has_depth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 2'd0 && !passAll) |-> (pageLevel != 2'd0));

  p_wb_page_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqWrite) |-> (memReqWdata[REF_BIT] && memReqWdata[1:0] == 2'd2));
endmodule

bind page_walker page_walker_chk #(.REF_BIT(REF_BIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .done        (done),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqWrite (memReqWrite),
  .memReqAddr  (memReqAddr),
  .memReqWdata (memReqWdata),
  .fault       (fault),
  .pageLevel   (pageLevel),
  .passAll     (passAll)
);

// File: tb/test_page_walker.sv
module test_page_walker;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reqValid, reqWrite, cfgEnable;
  logic [31:0] reqVaddr, cfgRootPtr;
  logic [7:0]  cfgContext;
  logic        memReqValid, memReqReady, memReqWrite;
  logic [31:0] memReqAddr, memReqWdata;
  logic        memRspValid;
  logic [31:0] memRspData;
  logic        busy, done, passAll;
  logic [31:0] paddr, pte;
  logic [1:0]  fault, pageLevel;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_walker i_page_walker (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .cfgEnable(cfgEnable), .cfgRootPtr(cfgRootPtr), .cfgContext(cfgContext),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqWdata(memReqWdata), .memRspValid(memRspValid),
    .memRspData(memRspData), .busy(busy), .done(done), .paddr(paddr), .pte(pte),
    .fault(fault), .pageLevel(pageLevel), .passAll(passAll)
  );

  typedef struct {
    string       tag;
    logic [31:0] paddr;
    logic [31:0] pte;
    logic [1:0]  fault;
    logic [1:0]  level;
    bit          pass;
    bit          wb;
    logic [31:0] wbAddr;
  } walk_item_t;

  logic [31:0] mem [logic [31:0]];
  walk_item_t  scoreQ [$];
  logic [31:0] expRd [$];
  int checks = 0, fails = 0, wrCount = 0, rdThisWalk = 0, doneSeen = 0;
  bit stallMode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] idxOf(input logic [31:0] va, input int lvl);
    if (lvl == 1) return (va >> 24) & 32'hff;
    if (lvl == 2) return (va >> 18) & 32'h3f;
    return (va >> 12) & 32'h3f;
  endfunction

  function automatic walk_item_t predict(input logic [31:0] va, input bit wr,
                                         input bit en, input string tag);
    walk_item_t it;
    logic [31:0] a, e, m, mask;
    it.tag = tag; it.pass = !en; it.paddr = 0; it.pte = 0; it.fault = 0;
    it.level = 0; it.wb = 0; it.wbAddr = 0;
    if (!en) begin it.paddr = va; return it; end
    a = (cfgRootPtr << 4) + ({24'h0, cfgContext} << 4);
    expRd.push_back(a);
    e = rd(a);
    for (int lvl = 0; lvl < 4; lvl++) begin
      if (e[1:0] == 2'd1) begin
        if (lvl == 3) begin it.fault = 2; it.pte = e; break; end
        a = ((e & ~32'h3) << 4) + (idxOf(va, lvl + 1) << 2);
        expRd.push_back(a);
        e = rd(a);
      end else if (e[1:0] == 2'd2) begin
        if (lvl == 0) begin it.fault = 2; it.pte = e; break; end
        mask = (lvl == 1) ? 32'hff_ffff : (lvl == 2) ? 32'h3_ffff : 32'hfff;
        it.paddr = ((e & 32'hffff_ff00) << 4) + (va & mask);
        m = e | 32'h20 | (wr ? 32'h40 : 32'h0);
        it.pte = m; it.level = 2'(lvl); it.wb = (m != e); it.wbAddr = a;
        break;
      end else begin
        it.fault = 1; it.pte = e; break;
      end
    end
    return it;
  endfunction

  // Memory model: ready pattern, read responses, write-backs, read address checks
  initial begin
    bit rdPending = 0, prevStall = 0, prevWr = 0;
    logic [31:0] rdData = 0, prevAddr = 0, e;
    int tick = 0;
    memReqReady = 0; memRspValid = 0; memRspData = 0;
    forever begin
      @(negedge clk);
      memRspValid = 0;
      if (rdPending) begin memRspValid = 1; memRspData = rdData; rdPending = 0; end
      if (prevStall)
        chk(memReqValid && memReqAddr == prevAddr && memReqWrite == prevWr, "R13",
            "request held under stall", memReqAddr, prevAddr);
      tick++;
      memReqReady = stallMode ? (tick % 3 == 0) : 1'b1;
      prevStall = memReqValid && !memReqReady;
      prevAddr = memReqAddr; prevWr = memReqWrite;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memReqAddr] = memReqWdata;
          wrCount++;
        end else begin
          if (expRd.size() == 0) begin
            chk(0, "R5", "unexpected read", memReqAddr, 32'h0);
          end else begin
            e = expRd.pop_front();
            chk(memReqAddr == e, (rdThisWalk == 0) ? "R3" : "R5", "read address", memReqAddr, e);
          end
          rdThisWalk++;
          rdData = rd(memReqAddr);
          rdPending = 1;
        end
      end
    end
  end

  // Monitor: pop expected results at each completion
  initial begin
    walk_item_t it;
    forever begin
      @(negedge clk);
      if (done && rst_n) begin
        if (scoreQ.size() == 0) begin
          chk(0, "R12", "completion without a walk", 32'h1, 32'h0);
        end else begin
          it = scoreQ.pop_front();
          chk(paddr == it.paddr, it.tag, "paddr", paddr, it.paddr);
          chk(pte == it.pte, it.tag, "pte", pte, it.pte);
          chk(fault == it.fault, it.tag, "fault", 32'(fault), 32'(it.fault));
          chk(pageLevel == it.level, it.tag, "pageLevel", 32'(pageLevel), 32'(it.level));
          chk(passAll == it.pass, it.tag, "passAll", 32'(passAll), 32'(it.pass));
          chk(wrCount == int'(it.wb), it.wb ? "R10" : it.tag, "write-back count",
              32'(wrCount), 32'(it.wb));
          if (it.wb)
            chk(rd(it.wbAddr) == it.pte, it.pte[6] ? "R11" : "R10", "stored entry",
                rd(it.wbAddr), it.pte);
          chk(expRd.size() == 0, "R5", "missing reads", 32'(expRd.size()), 32'h0);
        end
        doneSeen++;
        @(negedge clk);
        chk(!done && !busy, "R12", "done single pulse then idle", {30'h0, done, busy}, 32'h0);
      end
    end
  end

  task automatic walk(input logic [31:0] va, input bit wr, input bit en,
                      input bit hold, input string tag);
    int target;
    scoreQ.push_back(predict(va, wr, en, tag));
    wrCount = 0; rdThisWalk = 0;
    target = doneSeen + 1;
    @(negedge clk);
    cfgEnable = en; reqValid = 1; reqVaddr = va; reqWrite = wr;
    @(negedge clk);
    if (hold) begin
      reqVaddr = ~va; reqWrite = !wr;  // R12: must be ignored while busy
      @(negedge clk);
    end
    reqValid = 0;
    wait (doneSeen >= target);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    rst_n = 0; reqValid = 0; reqWrite = 0; reqVaddr = 0; cfgEnable = 1;
    cfgRootPtr = 32'h100; cfgContext = 8'd3;
    // Tables: root 0x1030 -> L1 0x2000 -> L2 0x3000 -> L3 0x4000
    mem[32'h1030] = 32'h0000_0201;
    mem[32'h1040] = 32'h0400_0022;          // page kind at root (ctx 4)
    mem[32'h2014] = 32'h0400_0002;          // L1[5]: 16MB page at 0x4000_0000, R clear
    mem[32'h201c] = 32'h0000_0301;          // L1[7]: link to 0x3000
    mem[32'h2024] = 32'h0000_0003;          // L1[9]: reserved
    mem[32'h3008] = 32'h0124_0022;          // L2[2]: 256KB page at 0x1240_0000, R set
    mem[32'h300c] = 32'h0000_0401;          // L2[3]: link to 0x4000
    mem[32'h4004] = 32'h0876_5302;          // L3[1]: 4KB page at 0x8765_3000, R clear
    mem[32'h4008] = 32'h0876_5362;          // L3[2]: R and M set
    mem[32'h400c] = 32'h0000_0501;          // L3[3]: link at last depth
    mem[32'h4010] = 32'h0000_0003;          // L3[4]: reserved
    repeat (3) @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1", "reset state",
        {29'h0, busy, done, memReqValid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !memReqValid, "R1", "idle after reset",
        {29'h0, busy, done, memReqValid}, 32'h0);

    walk(32'h0512_3456, 0, 1, 0, "R6");     // 16MB, write-back of R
    walk(32'h0512_3456, 1, 1, 0, "R11");    // store sets M
    walk(32'h0708_1234, 0, 1, 0, "R7");     // 256KB, R set: no write (R10)
    walk(32'h0708_1234, 1, 1, 0, "R11");
    stallMode = 1;
    walk(32'h070C_1ABC, 0, 1, 1, "R8");     // 4KB under stalls, held request (R12)
    walk(32'h070C_2FFF, 1, 1, 0, "R10");    // R and M set: no write
    walk(32'h070C_3000, 0, 1, 1, "R9");     // link at last depth
    stallMode = 0;
    walk(32'h070C_4000, 0, 1, 0, "R4");     // reserved, third table
    walk(32'h0710_0000, 1, 1, 0, "R4");     // empty, second table
    walk(32'h0900_0000, 0, 1, 0, "R4");     // reserved, first table
    walk(32'h0000_0000, 0, 1, 0, "R4");     // empty, first table
    cfgContext = 8'd4;
    walk(32'h0512_3456, 0, 1, 0, "R9");     // page kind at root
    cfgContext = 8'd5;
    walk(32'h0512_3456, 0, 1, 0, "R3");     // empty root at 0x1050
    walk(32'hDEAD_BEEF, 1, 0, 0, "R2");     // bypass, store
    walk(32'h0000_0FFC, 0, 0, 1, "R2");     // bypass, load
    repeat (4) @(negedge clk);
    chk(scoreQ.size() == 0, "R12", "all walks completed", 32'(scoreQ.size()), 32'h0);
    finishRun();
  end
endmodule